// File: doc/BRIEF.md
# Key Matrix Scanner With Shared Joystick Lines

This block keeps the pressed/released state of a keyboard laid out as 10 columns of 8 lines. A scanning processor puts a 4-bit BCD column number on `col_sel`. The block decodes that number to one column and returns that column's 8 line bits on `lines_n`. The bits are active low, so a held key reads as 0. The byte is meant to be presented on the input port of a sound generator chip, which the processor then reads back.

A digital joystick is wired onto the same line wires. Its common pin is fed from the tenth column (column 9), so its five switches appear on the lines only while that column is being scanned. Key events arrive as a column/line position plus a pressed flag. Translating host key codes to positions is left to the caller. Fixed positions that software relies on:

| Key | Column | Line |
|---|---|---|
| Shift | 2 | 5 |
| Ctrl | 2 | 7 |
| Return | 2 | 2 |
| Space | 5 | 7 |

Top module: `kbm_matrix_top`

## Requirements
- R1: Asserting `rst_n` low releases every key at once, without waiting for a clock. While no joystick bit is set, every column then reads 8'hFF.
- R2: A cycle with `ev_valid`=1, `ev_pressed`=1 and `ev_col` < 10 sets the key at (`ev_col`, `ev_line`) on that rising edge. From then on, bit `ev_line` of `lines_n` reads 0 while that column is selected.
- R3: A valid event with `ev_pressed`=0 releases that key on the edge, and its bit reads 1 again.
- R4: An event changes exactly one key. Every other key, in the same column or in other columns, keeps its state.
- R5: A `col_sel` value from 10 to 15 selects no column. `lines_n` is then 8'hFF, whatever the keys and the joystick are doing.
- R6: While `col_sel`=9, the joystick mask is ORed into the line bits before inversion. The bit map is up = bit 0, down = bit 1, left = bit 2, right = bit 3, fire = bit 4.
- R7: While any column other than 9 is selected, the joystick mask has no effect on `lines_n`.
- R8: When several keys in the selected column are held, each of them reads 0. The output is the inverted OR of the key bits.
- R9: A valid event whose `ev_col` is 10 to 15 changes no key.
- R10: A held Shift, Ctrl or Return key reads 0 at column 2, lines 5, 7 and 2 respectively. A held Space key reads 0 at column 5, line 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_valid | input | 1 | Key event strobe, one cycle per event |
| ev_col | input | 4 | Column of the key event |
| ev_line | input | 3 | Line of the key event |
| ev_pressed | input | 1 | 1 = press, 0 = release |
| joy_mask | input | 5 | Joystick switches, active high (up, down, left, right, fire from bit 0) |
| col_sel | input | 4 | BCD column select from the scanning port |
| lines_n | output | 8 | Active-low line byte of the selected column |

## Verification
On every cycle, the assertions check the following. A press or release lands on the addressed key on the next edge. No more than one key changes per cycle. Out-of-range event columns and idle cycles leave the state alone. Out-of-range selects read all ones. Any column other than 9 reads exactly the inverse of its stored key bits. The named key positions, the joystick bit map and the OR of several keys in one column depend on particular stimulus, so only the bench scenarios can show them. The same holds for the immediate clear on reset.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
  localparam int unsigned KBM_COLS    = 10;
  localparam int unsigned KBM_LINES   = 8;
  localparam int unsigned KBM_SEL_W   = 4;
  localparam int unsigned KBM_JOY_W   = 5;
  localparam int unsigned KBM_JOY_COL = 9;
endpackage

// File: rtl/kbm_rst_sync.sv
module kbm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/kbm_col_decode.sv
module kbm_col_decode #(
  parameter int unsigned NUM_COLS = 10,
  parameter int unsigned SEL_W    = 4
) (
  input  logic [SEL_W-1:0]    bcd,
  output logic [NUM_COLS-1:0] onehot
);
  // codes at or above NUM_COLS match no column
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign onehot[c] = (bcd == SEL_W'(c));
  end
endmodule

// File: rtl/kbm_key_store.sv
module kbm_key_store #(
  parameter int unsigned NUM_COLS  = 10,
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned KEYS     = NUM_COLS * NUM_LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_valid,
  input  logic [NUM_COLS-1:0] ev_col_hot,
  input  logic [LINE_W-1:0]   ev_line,
  input  logic                ev_pressed,
  output logic [KEYS-1:0]     key_flat
);
  logic [NUM_LINES-1:0] line_hot;

  always_comb begin
    line_hot          = '0;
    line_hot[ev_line] = 1'b1;
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [NUM_LINES-1:0] col_q;
    logic [NUM_LINES-1:0] col_d;
    logic                 col_we;

    always_comb begin
      col_we = ev_valid & ev_col_hot[c];
      col_d  = ev_pressed ? (col_q | line_hot) : (col_q & ~line_hot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      col_q <= '0;
      else if (col_we) col_q <= col_d;
    end

    assign key_flat[c*NUM_LINES +: NUM_LINES] = col_q;
  end
endmodule

// File: rtl/kbm_line_mux.sv
module kbm_line_mux #(
  parameter int unsigned NUM_COLS  = 10,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned JOY_W     = 5,
  parameter int unsigned JOY_COL   = 9,
  localparam int unsigned KEYS     = NUM_COLS * NUM_LINES
) (
  input  logic [NUM_COLS-1:0]  col_hot,
  input  logic [KEYS-1:0]      key_flat,
  input  logic [JOY_W-1:0]     joy_mask,
  output logic [NUM_LINES-1:0] lines_n
);
  logic [NUM_LINES-1:0] acc;

  always_comb begin
    acc = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (col_hot[c]) acc = acc | key_flat[c*NUM_LINES +: NUM_LINES];
    end
    // joystick common pin is powered from one column only
    if (col_hot[JOY_COL]) acc[JOY_W-1:0] = acc[JOY_W-1:0] | joy_mask;
    lines_n = ~acc;
  end
endmodule

// File: rtl/kbm_matrix_top.sv
module kbm_matrix_top
  import kbm_pkg::*;
#(
  parameter int unsigned NUM_COLS  = KBM_COLS,
  parameter int unsigned NUM_LINES = KBM_LINES,
  parameter int unsigned SEL_W     = KBM_SEL_W,
  parameter int unsigned JOY_W     = KBM_JOY_W,
  parameter int unsigned JOY_COL   = KBM_JOY_COL,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned KEYS     = NUM_COLS * NUM_LINES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  input  logic [SEL_W-1:0]     ev_col,
  input  logic [LINE_W-1:0]    ev_line,
  input  logic                 ev_pressed,
  input  logic [JOY_W-1:0]     joy_mask,
  input  logic [SEL_W-1:0]     col_sel,
  output logic [NUM_LINES-1:0] lines_n
);
  logic                rst_sync_n;
  logic [NUM_COLS-1:0] ev_hot;
  logic [NUM_COLS-1:0] sel_hot;
  logic [KEYS-1:0]     key_flat;

  kbm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  kbm_col_decode #(.NUM_COLS(NUM_COLS), .SEL_W(SEL_W)) u_ev_dec (
    .bcd    (ev_col),
    .onehot (ev_hot)
  );

  kbm_col_decode #(.NUM_COLS(NUM_COLS), .SEL_W(SEL_W)) u_sel_dec (
    .bcd    (col_sel),
    .onehot (sel_hot)
  );

  kbm_key_store #(.NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ev_valid   (ev_valid),
    .ev_col_hot (ev_hot),
    .ev_line    (ev_line),
    .ev_pressed (ev_pressed),
    .key_flat   (key_flat)
  );

  kbm_line_mux #(
    .NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES),
    .JOY_W(JOY_W), .JOY_COL(JOY_COL)
  ) u_mux (
    .col_hot  (sel_hot),
    .key_flat (key_flat),
    .joy_mask (joy_mask),
    .lines_n  (lines_n)
  );
endmodule

// File: rtl/kbm_matrix_chk.sv
module kbm_matrix_chk #(
  parameter int unsigned NUM_COLS  = 10,
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned JOY_COL   = 9,
  localparam int unsigned LINE_W   = $clog2(NUM_LINES),
  localparam int unsigned KEYS     = NUM_COLS * NUM_LINES,
  localparam int unsigned IDX_W    = $clog2(KEYS) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_ok,
  input logic                 ev_valid,
  input logic [SEL_W-1:0]     ev_col,
  input logic [LINE_W-1:0]    ev_line,
  input logic                 ev_pressed,
  input logic [SEL_W-1:0]     col_sel,
  input logic [NUM_LINES-1:0] lines_n,
  input logic [KEYS-1:0]      key_state
);
  logic [IDX_W-1:0] ev_idx;
  logic [IDX_W-1:0] sel_base;
  logic             ev_in_range;
  logic             sel_in_range;

  always_comb begin
    ev_idx       = IDX_W'(ev_col) * IDX_W'(NUM_LINES) + IDX_W'(ev_line);
    sel_base     = IDX_W'(col_sel) * IDX_W'(NUM_LINES);
    ev_in_range  = (ev_col < SEL_W'(NUM_COLS));
    sel_in_range = (col_sel < SEL_W'(NUM_COLS));
  end

  // R1: when the internal reset lifts, every key is released
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> (key_state == '0));

  // R2: a press lands on the addressed key on the next edge
  p_press_lands_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (ev_valid && ev_pressed && ev_in_range) |=> key_state[$past(ev_idx)]);

  // R3: a release clears the addressed key
  p_release_lands_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (ev_valid && !ev_pressed && ev_in_range) |=> !key_state[$past(ev_idx)]);

  // R4: at most one key changes per cycle
  p_one_key_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ($countones(key_state ^ $past(key_state)) <= 1));

  // R9: no valid in-range event, no change
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (!ev_valid || !ev_in_range) |=> $stable(key_state));

  // R5: out-of-range select reads all ones
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    !sel_in_range |-> (lines_n == '1));

  // R7: non-joystick columns show only their keys
  p_joy_off_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (sel_in_range && (col_sel != SEL_W'(JOY_COL)))
      |-> (lines_n == ~key_state[sel_base +: NUM_LINES]));
endmodule

bind kbm_matrix_top kbm_matrix_chk #(
  .NUM_COLS(NUM_COLS), .NUM_LINES(NUM_LINES),
  .SEL_W(SEL_W), .JOY_COL(JOY_COL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_ok     (rst_sync_n),
  .ev_valid   (ev_valid),
  .ev_col     (ev_col),
  .ev_line    (ev_line),
  .ev_pressed (ev_pressed),
  .col_sel    (col_sel),
  .lines_n    (lines_n),
  .key_state  (key_flat)
);

// File: tb/tb_kbm_matrix_top.sv
module tb_kbm_matrix_top;
  logic       clk;
  logic       rst_n;
  logic       ev_valid;
  logic [3:0] ev_col;
  logic [2:0] ev_line;
  logic       ev_pressed;
  logic [4:0] joy_mask;
  logic [3:0] col_sel;
  logic [7:0] lines_n;

  int checks;
  int fails;
  bit done;

  kbm_matrix_top dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_col(ev_col),
    .ev_line(ev_line), .ev_pressed(ev_pressed), .joy_mask(joy_mask),
    .col_sel(col_sel), .lines_n(lines_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // op(2) col(4) line(3) joy(5) sel(4) expected(8); op 1 = press, 2 = release
  localparam int NV = 19;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 4'd2,  3'd5, 5'h00, 4'd2,  8'hDF},
    {2'd1, 4'd2,  3'd7, 5'h00, 4'd2,  8'h5F},
    {2'd1, 4'd2,  3'd2, 5'h00, 4'd2,  8'h5B},
    {2'd0, 4'd0,  3'd0, 5'h00, 4'd3,  8'hFF},
    {2'd1, 4'd5,  3'd7, 5'h00, 4'd5,  8'h7F},
    {2'd0, 4'd0,  3'd0, 5'h00, 4'd2,  8'h5B},
    {2'd2, 4'd2,  3'd7, 5'h00, 4'd2,  8'hDB},
    {2'd0, 4'd0,  3'd0, 5'h1F, 4'd9,  8'hE0},
    {2'd0, 4'd0,  3'd0, 5'h1F, 4'd5,  8'h7F},
    {2'd1, 4'd9,  3'd7, 5'h01, 4'd9,  8'h7E},
    {2'd0, 4'd0,  3'd0, 5'h04, 4'd9,  8'h7B},
    {2'd0, 4'd0,  3'd0, 5'h1F, 4'd12, 8'hFF},
    {2'd1, 4'd12, 3'd0, 5'h00, 4'd0,  8'hFF},
    {2'd1, 4'd15, 3'd3, 5'h00, 4'd7,  8'hFF},
    {2'd0, 4'd0,  3'd0, 5'h08, 4'd15, 8'hFF},
    {2'd2, 4'd5,  3'd7, 5'h00, 4'd5,  8'hFF},
    {2'd1, 4'd0,  3'd0, 5'h00, 4'd0,  8'hFE},
    {2'd1, 4'd9,  3'd0, 5'h10, 4'd9,  8'h6E},
    {2'd0, 4'd0,  3'd0, 5'h02, 4'd9,  8'h7C}
  };
  localparam string TAGS [NV] = '{
    "R2 R10 shift", "R8 R10 ctrl", "R8 R10 return", "R4 other column",
    "R10 space", "R4 same column kept", "R3 release ctrl", "R6 joystick all",
    "R7 joystick masked", "R6 up plus key", "R6 left", "R5 sel 12",
    "R9 column 12 event", "R9 column 15 event", "R5 sel 15",
    "R3 release space", "R2 corner key", "R6 fire", "R6 down"
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: lines_n=%02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [3:0] c, input logic [2:0] l, input logic p);
    @(negedge clk);
    ev_col = c; ev_line = l; ev_pressed = p; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; ev_valid = 1'b0; ev_col = '0; ev_line = '0;
    ev_pressed = 1'b0; joy_mask = '0; col_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state, every select value
    for (int s = 0; s < 16; s++) begin
      col_sel = 4'(s); #1;
      check("R1 reset state", lines_n, 8'hFF);
    end

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      if (v[25:24] != 2'd0) send(v[23:20], v[19:17], v[25:24] == 2'd1);
      joy_mask = v[16:12];
      col_sel  = v[11:8];
      #2;
      check(TAGS[i], lines_n, v[7:0]);
    end

    // R9: out-of-range events disturbed no column
    joy_mask = '0;
    for (int s = 1; s < 9; s++) begin
      col_sel = 4'(s); #1;
      check("R9 columns untouched", lines_n, (s == 2) ? 8'hDB : 8'hFF);
    end

    // R1: asynchronous clear mid-run
    @(negedge clk);
    col_sel = 4'd2;
    rst_n = 1'b0; #1;
    check("R1 async clear", lines_n, 8'hFF);
    col_sel = 4'd9; #1;
    check("R1 async clear joy col", lines_n, 8'hFF);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    col_sel = 4'd0; #1;
    check("R1 after release", lines_n, 8'hFF);

    // R2 R3: press and release the same key back to back
    send(4'd3, 3'd4, 1'b1);
    col_sel = 4'd3; #1;
    check("R2 press line 4", lines_n, 8'hEF);
    send(4'd3, 3'd4, 1'b0);
    #1;
    check("R3 release line 4", lines_n, 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule